// File: doc/BRIEF.md
# Multi-Port GPIO Register Slave

This block is the register front end of a general-purpose I/O controller on an APB bus. It serves up to four ports, each up to 32 lines wide. For each port it stores an output value and a per-line direction, drives the pad output and output-enable vectors from them, and returns the pin levels after a two-flop synchronizer. Port value and direction registers sit in pairs 0x0c apart. The pin level registers are packed 0x04 apart starting at 0x50.

Interrupt detection lives in a separate unit. This slave only decodes the interrupt register offsets and forwards each access to that unit. It sends a register identifier, a write flag and the write data, and it returns the unit's read data on the bus. A static layout input selects one of two address maps for the interrupt registers. The slave always completes a transfer in the minimum two cycles and never reports an error.

Top module: `gpio_regs_top`

## Requirements
- R1: After reset every data and direction register is zero, so `padOut` and `padOe` are all zero and reads of those registers return zero.
- R2: Port p (p = 0..NUM_PORTS-1) has its output value register at byte offset 0x0c*p and its direction register at 0x0c*p+4. Both can be written and read back.
- R3: Bit i of port p drives `padOe[p*PORT_W+i]` from the direction register and `padOut[p*PORT_W+i]` from the output value register. A direction bit of 1 makes the line an output. A write takes effect at the clock edge that ends the access phase.
- R4: Reading 0x50+4*p returns port p's `pinIn` slice after two synchronizing flops. A pin change made just after edge E is first returned by an access phase that starts at edge E+2 or later.
- R5: With `layoutAlt`=0, the interrupt offsets forward with this `irqRegId` encoding: 0x30 enable=0, 0x34 mask=1, 0x38 type=2, 0x3c polarity=3, 0x40 status=4, 0x48 debounce=5, 0x4c end-of-interrupt=6.
- R6: With `layoutAlt`=1, the offsets map as follows: mask at 0x44 (id 1), type at 0x34 (id 2), polarity at 0x38 (id 3), status at 0x3c (id 4), end-of-interrupt at 0x40 (id 6). Enable (0x30, id 0) and debounce (0x48, id 5) do not move.
- R7: `irqAccess` is high only during the access phase of an interrupt register transfer. During that phase `irqWrite` equals `pwrite`, `irqWdata` carries `pwdata`, and on a read `prdata` returns `irqRdata`.
- R8: `pready` is high and `pslverr` is low in every access phase.
- R9: Reads of unmapped offsets return zero, and writes to them change no register. This covers 0x08, 0x60, 0x44 in the default layout and 0x4c in the alternate layout.
- R10: A setup phase that is not followed by an access phase (`penable` low) writes nothing.
- R11: The pin level registers are read-only. Writing them leaves the value read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always no error |
| layoutAlt | input | 1 | Interrupt register layout select (static) |
| pinIn | input | NUM_PORTS*PORT_W | Asynchronous pin levels |
| padOut | output | NUM_PORTS*PORT_W | Pad output values |
| padOe | output | NUM_PORTS*PORT_W | Pad output enables |
| irqAccess | output | 1 | Interrupt register access strobe |
| irqWrite | output | 1 | Interrupt access is a write |
| irqRegId | output | 3 | Interrupt register identifier |
| irqWdata | output | 32 | Write data to interrupt unit |
| irqRdata | input | 32 | Read data from interrupt unit |

## Verification
The assertions watch, on every cycle, that port A's pad vectors follow writes one edge later and hold when no write happens. They also check that the pin readback at 0x50 equals the pin level from two edges before, and that interrupt forwarding appears only in access phases and returns the interrupt unit's data. The enable and relocated mask offsets are checked as well. The bench scenarios alone show the full offset table in both layouts, the unmapped and read-only offsets, the higher ports, the reset state, and the boundary between old and new pin values seen by back-to-back reads.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int MAX_PORTS   = 4;
  localparam int BUS_W       = 32;
  localparam int PORT_STRIDE = 12;
  localparam int DIR_OFS     = 4;
  localparam int PIN_BASE    = 80;
  localparam int PIN_STRIDE  = 4;
  // interrupt offsets, both layouts
  localparam int OFS_ENABLE    = 'h30;
  localparam int OFS_DEBOUNCE  = 'h48;
  localparam int DEF_MASK      = 'h34;
  localparam int DEF_TYPE      = 'h38;
  localparam int DEF_POLARITY  = 'h3c;
  localparam int DEF_STATUS    = 'h40;
  localparam int DEF_EOI       = 'h4c;
  localparam int ALT_MASK      = 'h44;
  localparam int ALT_TYPE      = 'h34;
  localparam int ALT_POLARITY  = 'h38;
  localparam int ALT_STATUS    = 'h3c;
  localparam int ALT_EOI       = 'h40;

  typedef enum logic [2:0] {
    IRQ_ENABLE   = 3'd0,
    IRQ_MASK     = 3'd1,
    IRQ_TYPE     = 3'd2,
    IRQ_POLARITY = 3'd3,
    IRQ_STATUS   = 3'd4,
    IRQ_DEBOUNCE = 3'd5,
    IRQ_EOI      = 3'd6
  } irqReg_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_DATA = 3'd1,
    SRC_DIR  = 3'd2,
    SRC_PIN  = 3'd3,
    SRC_IRQ  = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic [MAX_PORTS-1:0] dataWe;
    logic [MAX_PORTS-1:0] dirWe;
    rdSrc_e               rdSrc;
    logic [1:0]           rdPort;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstn,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/gpio_regs_ctrl.sv
module gpio_regs_ctrl
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              layoutAlt,
  output ctrlStrobes_t      strobes,
  output logic              irqAccess,
  output logic              irqWrite,
  output irqReg_e           irqRegId
);
  logic    access;
  rdSrc_e  hitSrc;
  logic [1:0] hitPort;
  logic    irqHit;
  irqReg_e irqSel;

  assign access = psel && penable;

  // port register decode
  always_comb begin
    hitSrc  = SRC_NONE;
    hitPort = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (paddr == ADDR_W'(PORT_STRIDE * p)) begin
        hitSrc  = SRC_DATA;
        hitPort = 2'(p);
      end
      if (paddr == ADDR_W'(PORT_STRIDE * p + DIR_OFS)) begin
        hitSrc  = SRC_DIR;
        hitPort = 2'(p);
      end
      if (paddr == ADDR_W'(PIN_BASE + PIN_STRIDE * p)) begin
        hitSrc  = SRC_PIN;
        hitPort = 2'(p);
      end
    end
  end

  // interrupt register decode, layout dependent
  always_comb begin
    irqHit = 1'b1;
    irqSel = IRQ_ENABLE;
    if (paddr == ADDR_W'(OFS_ENABLE))        irqSel = IRQ_ENABLE;
    else if (paddr == ADDR_W'(OFS_DEBOUNCE)) irqSel = IRQ_DEBOUNCE;
    else if (!layoutAlt) begin
      if      (paddr == ADDR_W'(DEF_MASK))     irqSel = IRQ_MASK;
      else if (paddr == ADDR_W'(DEF_TYPE))     irqSel = IRQ_TYPE;
      else if (paddr == ADDR_W'(DEF_POLARITY)) irqSel = IRQ_POLARITY;
      else if (paddr == ADDR_W'(DEF_STATUS))   irqSel = IRQ_STATUS;
      else if (paddr == ADDR_W'(DEF_EOI))      irqSel = IRQ_EOI;
      else                                     irqHit = 1'b0;
    end else begin
      if      (paddr == ADDR_W'(ALT_MASK))     irqSel = IRQ_MASK;
      else if (paddr == ADDR_W'(ALT_TYPE))     irqSel = IRQ_TYPE;
      else if (paddr == ADDR_W'(ALT_POLARITY)) irqSel = IRQ_POLARITY;
      else if (paddr == ADDR_W'(ALT_STATUS))   irqSel = IRQ_STATUS;
      else if (paddr == ADDR_W'(ALT_EOI))      irqSel = IRQ_EOI;
      else                                     irqHit = 1'b0;
    end
  end

  // strobes to the datapath
  always_comb begin
    strobes = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      strobes.dataWe[p] = access && pwrite && (hitSrc == SRC_DATA) && (hitPort == 2'(p));
      strobes.dirWe[p]  = access && pwrite && (hitSrc == SRC_DIR)  && (hitPort == 2'(p));
    end
    if (access && !pwrite) begin
      strobes.rdSrc  = irqHit ? SRC_IRQ : hitSrc;
      strobes.rdPort = hitPort;
    end
  end

  assign irqAccess = access && irqHit;
  assign irqWrite  = access && irqHit && pwrite;
  assign irqRegId  = irqSel;
endmodule

// File: rtl/gpio_regs_datapath.sv
module gpio_regs_datapath
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstn,
  input  ctrlStrobes_t                strobes,
  input  logic [BUS_W-1:0]            wdata,
  input  logic [BUS_W-1:0]            irqRdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [NUM_PORTS*PORT_W-1:0] padOut,
  output logic [NUM_PORTS*PORT_W-1:0] padOe,
  output logic [BUS_W-1:0]            rdData
);
  logic [PORT_W-1:0] dataQ [NUM_PORTS];
  logic [PORT_W-1:0] dirQ  [NUM_PORTS];
  logic [PORT_W-1:0] pinQ  [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstn) begin
      if (!rstn) begin
        dataQ[p] <= '0;
        dirQ[p]  <= '0;
      end else begin
        if (strobes.dataWe[p]) dataQ[p] <= wdata[PORT_W-1:0];
        if (strobes.dirWe[p])  dirQ[p]  <= wdata[PORT_W-1:0];
      end
    end

    gpio_pin_sync #(.WIDTH(PORT_W)) u_sync (
      .clk  (clk),
      .rstn (rstn),
      .din  (pinIn[p*PORT_W +: PORT_W]),
      .dout (pinQ[p])
    );

    assign padOut[p*PORT_W +: PORT_W] = dataQ[p];
    assign padOe[p*PORT_W +: PORT_W]  = dirQ[p];
  end

  logic [PORT_W-1:0] dataSel, dirSel, pinSel;

  always_comb begin
    dataSel = '0;
    dirSel  = '0;
    pinSel  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (int'(strobes.rdPort) == p) begin
        dataSel = dataQ[p];
        dirSel  = dirQ[p];
        pinSel  = pinQ[p];
      end
    end
    case (strobes.rdSrc)
      SRC_DATA: rdData = BUS_W'(dataSel);
      SRC_DIR:  rdData = BUS_W'(dirSel);
      SRC_PIN:  rdData = BUS_W'(pinSel);
      SRC_IRQ:  rdData = irqRdata;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_regs_top.sv
module gpio_regs_top
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  output logic                        pslverr,
  input  logic                        layoutAlt,
  input  logic [NUM_PORTS*PORT_W-1:0] pinIn,
  output logic [NUM_PORTS*PORT_W-1:0] padOut,
  output logic [NUM_PORTS*PORT_W-1:0] padOe,
  output logic                        irqAccess,
  output logic                        irqWrite,
  output logic [2:0]                  irqRegId,
  output logic [31:0]                 irqWdata,
  input  logic [31:0]                 irqRdata
);
  ctrlStrobes_t strobes;
  irqReg_e      irqSel;

  gpio_regs_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_ctrl (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .layoutAlt (layoutAlt),
    .strobes   (strobes),
    .irqAccess (irqAccess),
    .irqWrite  (irqWrite),
    .irqRegId  (irqSel)
  );

  gpio_regs_datapath #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_dp (
    .clk      (pclk),
    .rstn     (presetn),
    .strobes  (strobes),
    .wdata    (pwdata),
    .irqRdata (irqRdata),
    .pinIn    (pinIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .rdData   (prdata)
  );

  assign irqRegId = irqSel;
  assign irqWdata = pwdata;
  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
endmodule

// File: rtl/gpio_regs_checker.sv
module gpio_regs_checker #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                        pclk,
  input logic                        presetn,
  input logic                        psel,
  input logic                        penable,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [31:0]                 pwdata,
  input logic [31:0]                 prdata,
  input logic                        layoutAlt,
  input logic [NUM_PORTS*PORT_W-1:0] pinIn,
  input logic [NUM_PORTS*PORT_W-1:0] padOut,
  input logic [NUM_PORTS*PORT_W-1:0] padOe,
  input logic                        irqAccess,
  input logic [2:0]                  irqRegId,
  input logic [31:0]                 irqRdata
);
  logic       access;
  logic [1:0] sinceRst;

  assign access = psel && penable;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)            sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_DATA_TO_PAD: assert property (@(posedge pclk) disable iff (!presetn)
    (sinceRst != 0 && access && pwrite && paddr == ADDR_W'(0))
      |=> padOut[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])); // R3

  AST_DIR_TO_OE: assert property (@(posedge pclk) disable iff (!presetn)
    (sinceRst != 0 && access && pwrite && paddr == ADDR_W'(4))
      |=> padOe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])); // R3

  AST_PAD_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
    (sinceRst != 0 && !(access && pwrite))
      |=> ($stable(padOut) && $stable(padOe))); // R10

  AST_PIN_SYNC: assert property (@(posedge pclk) disable iff (!presetn)
    (sinceRst == 2'd3 && access && !pwrite && paddr == ADDR_W'('h50))
      |-> prdata[PORT_W-1:0] == $past(pinIn[PORT_W-1:0], 2)); // R4

  AST_IRQ_ENABLE_FWD: assert property (@(posedge pclk) disable iff (!presetn)
    (access && paddr == ADDR_W'('h30)) |-> (irqAccess && irqRegId == 3'd0)); // R5

  AST_IRQ_ALT_MASK: assert property (@(posedge pclk) disable iff (!presetn)
    (access && layoutAlt && paddr == ADDR_W'('h44)) |-> (irqAccess && irqRegId == 3'd1)); // R6

  AST_IRQ_READ: assert property (@(posedge pclk) disable iff (!presetn)
    (irqAccess && !pwrite) |-> prdata == irqRdata); // R7

  AST_IRQ_ONLY_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
    !access |-> !irqAccess); // R7
endmodule

bind gpio_regs_top gpio_regs_checker #(
  .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_checker (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
  .layoutAlt(layoutAlt), .pinIn(pinIn), .padOut(padOut), .padOe(padOe),
  .irqAccess(irqAccess), .irqRegId(irqRegId), .irqRdata(irqRdata)
);

// File: tb/tb_gpio_regs_top.sv
`timescale 1ns/1ps
module tb_gpio_regs_top;
  localparam int NP = 4;
  localparam int PW = 32;
  localparam int AW = 8;

  logic              pclk = 1'b0;
  logic              presetn = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0]     paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic              layoutAlt = 1'b0;
  logic [NP*PW-1:0]  pinIn = '0;
  logic [NP*PW-1:0]  padOut, padOe;
  logic              irqAccess, irqWrite;
  logic [2:0]        irqRegId;
  logic [31:0]       irqWdata, irqRdata;

  // interrupt unit model: answers with a tag of the selected register
  assign irqRdata = 32'hC0DE_0000 | {29'd0, irqRegId};

  always #2 pclk = ~pclk; // 250 MHz

  gpio_regs_top #(.NUM_PORTS(NP), .PORT_W(PW), .ADDR_W(AW)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .layoutAlt(layoutAlt),
    .pinIn(pinIn), .padOut(padOut), .padOe(padOe),
    .irqAccess(irqAccess), .irqWrite(irqWrite), .irqRegId(irqRegId),
    .irqWdata(irqWdata), .irqRdata(irqRdata)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t sbq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every access phase is checked for handshake, reads are scored
  always @(negedge pclk) begin
    if (psel && penable) begin
      check(pready && !pslverr, "R8 ready/no error", {30'd0, pready, pslverr}, 32'h2);
      if (!pwrite) begin
        if (sbq.size() == 0) begin
          check(1'b0, "scoreboard underflow", prdata, 32'h0);
        end else begin
          expItem_t it;
          it = sbq.pop_front();
          check(prdata === it.exp, it.tag, prdata, it.exp);
        end
      end
    end
  end

  // all transfer tasks start just after a rising edge and end just after one
  task automatic apbWrite(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic irqWriteCheck(input logic [AW-1:0] a, input logic [31:0] d,
                               input logic [2:0] expId, input string tag);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge pclk); #1;
    penable = 1'b1;
    @(negedge pclk);
    check(irqAccess && irqWrite && irqRegId == expId && irqWdata == d, tag,
          {irqAccess, irqWrite, 27'd0, irqRegId}, {2'b11, 27'd0, expId});
    @(posedge pclk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NP*PW-1:0] outSnap, oeSnap;
    repeat (3) @(posedge pclk);
    #1 presetn = 1'b1;
    @(posedge pclk); #1;

    // R1 reset state
    check(padOut == '0, "R1 padOut reset", padOut[31:0], 32'h0);
    check(padOe == '0, "R1 padOe reset", padOe[31:0], 32'h0);
    apbRead(8'h00, 32'h0, "R1 port A data reset");
    apbRead(8'h28, 32'h0, "R1 port D dir reset");

    // R2/R3 port A
    apbWrite(8'h00, 32'hDEAD_BEEF);
    check(padOut[31:0] == 32'hDEAD_BEEF, "R3 port A padOut", padOut[31:0], 32'hDEAD_BEEF);
    apbWrite(8'h04, 32'h0000_FFFF);
    check(padOe[31:0] == 32'h0000_FFFF, "R3 port A padOe", padOe[31:0], 32'h0000_FFFF);
    apbRead(8'h00, 32'hDEAD_BEEF, "R2 port A data readback");
    apbRead(8'h04, 32'h0000_FFFF, "R2 port A dir readback");

    // R2/R3 port D and port B
    apbWrite(8'h24, 32'h1357_9BDF);
    apbWrite(8'h28, 32'hF0F0_0F0F);
    check(padOut[127:96] == 32'h1357_9BDF, "R3 port D padOut", padOut[127:96], 32'h1357_9BDF);
    check(padOe[127:96] == 32'hF0F0_0F0F, "R3 port D padOe", padOe[127:96], 32'hF0F0_0F0F);
    check(padOut[63:32] == 32'h0, "R3 port B untouched", padOut[63:32], 32'h0);
    apbRead(8'h24, 32'h1357_9BDF, "R2 port D data readback");
    apbWrite(8'h10, 32'h8000_0001);
    apbRead(8'h10, 32'h8000_0001, "R2 port B dir readback");
    apbRead(8'h0c, 32'h0, "R2 port B data still zero");

    // R4 synchronizer latency on port B
    pinIn[63:32] = 32'h1234_5678;
    apbRead(8'h54, 32'h0, "R4 old pin value within two edges");
    apbRead(8'h54, 32'h1234_5678, "R4 new pin value after two edges");
    pinIn[95:64] = 32'hA5A5_0001;
    repeat (3) @(posedge pclk); #1;
    apbRead(8'h58, 32'hA5A5_0001, "R4 port C pin readback");
    apbRead(8'h50, 32'h0, "R4 port A pins zero");

    // R11 pin registers read-only
    apbWrite(8'h54, 32'hFFFF_FFFF);
    apbRead(8'h54, 32'h1234_5678, "R11 pin register unchanged");

    // R9 unmapped writes and reads
    outSnap = padOut; oeSnap = padOe;
    apbWrite(8'h08, 32'hFFFF_FFFF);
    apbWrite(8'h60, 32'hFFFF_FFFF);
    check(padOut == outSnap && padOe == oeSnap, "R9 unmapped write no effect", padOut[31:0], outSnap[31:0]);
    apbRead(8'h08, 32'h0, "R9 read 0x08");
    apbRead(8'h60, 32'h0, "R9 read 0x60");
    apbRead(8'h44, 32'h0, "R9 read 0x44 default layout");

    // R10 setup without access
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0;
    @(posedge pclk); #1;
    psel = 1'b0; pwrite = 1'b0;
    @(posedge pclk); #1;
    check(padOut[31:0] == 32'hDEAD_BEEF, "R10 setup-only no write", padOut[31:0], 32'hDEAD_BEEF);

    // R5 default interrupt layout
    apbRead(8'h30, 32'hC0DE_0000, "R5 enable");
    apbRead(8'h34, 32'hC0DE_0001, "R5 mask");
    apbRead(8'h38, 32'hC0DE_0002, "R5 type");
    apbRead(8'h3c, 32'hC0DE_0003, "R5 polarity");
    apbRead(8'h40, 32'hC0DE_0004, "R5 status");
    apbRead(8'h48, 32'hC0DE_0005, "R5 debounce");
    apbRead(8'h4c, 32'hC0DE_0006, "R5 end-of-interrupt");
    irqWriteCheck(8'h34, 32'h0000_00F0, 3'd1, "R7 write mask default");

    // R6 alternate layout
    layoutAlt = 1'b1;
    @(posedge pclk); #1;
    apbRead(8'h30, 32'hC0DE_0000, "R6 enable");
    apbRead(8'h44, 32'hC0DE_0001, "R6 mask");
    apbRead(8'h34, 32'hC0DE_0002, "R6 type");
    apbRead(8'h38, 32'hC0DE_0003, "R6 polarity");
    apbRead(8'h3c, 32'hC0DE_0004, "R6 status");
    apbRead(8'h40, 32'hC0DE_0006, "R6 end-of-interrupt");
    apbRead(8'h48, 32'hC0DE_0005, "R6 debounce");
    apbRead(8'h4c, 32'h0, "R9 read 0x4c alternate layout");
    irqWriteCheck(8'h40, 32'hFFFF_FFFF, 3'd6, "R7 write eoi alternate");
    apbRead(8'h00, 32'hDEAD_BEEF, "R6 port data unmoved");
    check(irqAccess == 1'b0, "R7 no forward when idle", {31'd0, irqAccess}, 32'h0);

    repeat (2) @(posedge pclk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 32'h0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule